// File: doc/BRIEF.md
# Peripheral Write Guard with Set/Clear Protection Register

This block sits next to an APB bridge and keeps one write-protect bit for each peripheral behind that bridge. Software changes the bits through two word addresses of a small APB register port. One address sets the bits written as 1 and the other clears them, so no read-modify-write is ever needed. Both addresses read back the same vector.

The block observes the bridge's downstream transfer: the one-hot peripheral select, enable and write strobes, and a debug qualifier. The decision is taken in the setup cycle. If a write targets a protected peripheral and the debug qualifier is low, the enable toward the peripheral is held low in the access cycle. The block then completes the transfer itself with ready and an access error. Otherwise the peripheral's own ready and error pass back unchanged.

As a program-flow guard, a protect request for a peripheral that is already protected returns an error, and so does an unprotect request for one that is already unprotected. The other requested bits in that same write are still applied.

Top module: `apb_wprot_ctrl`

## Requirements
- R1: After reset every protection bit is 0 (unprotected), a read of either alias returns 0, and `pslverr` is low.
- R2: A write to the set alias (byte offset 0x4) sets every protection bit whose `pwdata` bit is 1. Bits written as 0 keep their value.
- R3: A write to the clear alias (byte offset 0x0) clears every protection bit whose `pwdata` bit is 1. Bits written as 0 keep their value.
- R4: A read of either alias returns the protection vector in bits NUM_PERIPH-1:0, with the upper bits zero. Any other address, including unaligned ones, reads 0 and ignores writes without error.
- R5: A set-alias write with a 1 on any already-set bit returns `pslverr` high in its access cycle.
- R6: A clear-alias write with a 1 on any already-clear bit returns `pslverr` high in its access cycle.
- R7: A downstream write is blocked when, in its setup cycle, its selected peripheral's bit (bit n for `bus_sel_i[n]`) is 1 and `dbg_access_i` is 0. In the access cycle of a blocked write, `dev_enable_o` is low while `bus_ready_o` and `bus_slverr_o` are high.
- R8: A downstream write with `dbg_access_i` high in its setup cycle is never blocked. The enable passes through, and ready and error come from the peripheral.
- R9: Downstream reads and writes to unprotected peripherals pass through. `dev_enable_o` follows `bus_enable_i`, `bus_ready_o` follows `dev_ready_i`, and `bus_slverr_o` follows `dev_slverr_i`.
- R10: The register port never inserts wait states: `pready` is always high. `pslverr` is high only in an access cycle.
- R11: A register write takes effect for downstream writes whose setup cycle comes after that register write's access cycle. A downstream setup cycle that shares a clock edge with a register access cycle uses the old protection state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port enable (access phase) |
| pwrite | input | 1 | Register port write strobe |
| paddr | input | ADDR_W | Register port byte address |
| pwdata | input | DATA_W | Register port write data, one bit per peripheral |
| prdata | output | DATA_W | Register port read data |
| pready | output | 1 | Register port ready, always high |
| pslverr | output | 1 | Register port error (double protect/unprotect) |
| bus_sel_i | input | NUM_PERIPH | Bridge one-hot peripheral select |
| bus_enable_i | input | 1 | Bridge downstream enable |
| bus_write_i | input | 1 | Bridge downstream write strobe |
| dbg_access_i | input | 1 | Debug qualifier, bypasses protection |
| dev_ready_i | input | 1 | Ready from the selected peripheral |
| dev_slverr_i | input | 1 | Error from the selected peripheral |
| dev_enable_o | output | 1 | Gated enable toward the peripherals |
| bus_ready_o | output | 1 | Ready returned to the bridge |
| bus_slverr_o | output | 1 | Error returned to the bridge |

## Verification
A register write's access edge and a downstream write's setup edge can land on the same clock. In that case the protection vector changes while the guard samples it. The bench provokes this by starting a downstream write one cycle after a register set or clear. It does this both for a bit going from 0 to 1 and for a bit going from 1 to 0. The first downstream write must see the old state, and a repeat of it right after must see the new one.

// File: rtl/apb_wprot_pkg.sv
package apb_wprot_pkg;

  // Register window hit by the current register-port address.
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_CLR  = 2'd1,
    WIN_SET  = 2'd2
  } win_e;

  // Word indices of the two aliases (byte offsets 0x0 and 0x4).
  localparam int CLR_WORD = 0;
  localparam int SET_WORD = 1;

endpackage

// File: rtl/wprot_regs.sv
module wprot_regs
  import apb_wprot_pkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [DATA_W-1:0]     pwdata,
  output logic [DATA_W-1:0]     prdata,
  output logic                  pslverr,
  output logic [NUM_PERIPH-1:0] prot_o
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]     word_idx;
  win_e                  win;
  logic [NUM_PERIPH-1:0] req;
  logic [NUM_PERIPH-1:0] prot_q;
  logic [NUM_PERIPH-1:0] prot_nxt;
  logic                  dup;
  logic                  setup_ph;
  logic                  wr_commit;

  assign word_idx  = paddr[ADDR_W-1:2];
  assign req       = pwdata[NUM_PERIPH-1:0];
  assign setup_ph  = psel & ~penable;
  assign wr_commit = psel & penable & pwrite;

  // Upper data bits carry no protection bits.
  generate
    if (DATA_W > NUM_PERIPH) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^pwdata[DATA_W-1:NUM_PERIPH];
    end
  endgenerate

  always_comb begin
    win = WIN_NONE;
    if (paddr[1:0] == 2'b00) begin
      if (word_idx == WORD_W'(CLR_WORD))      win = WIN_CLR;
      else if (word_idx == WORD_W'(SET_WORD)) win = WIN_SET;
    end
  end

  // A requested bit already in the requested state is a flow violation.
  always_comb begin
    case (win)
      WIN_SET: dup = |(req & prot_q);
      WIN_CLR: dup = |(req & ~prot_q);
      default: dup = 1'b0;
    endcase
  end

  always_comb begin
    case (win)
      WIN_SET: prot_nxt = prot_q | req;
      WIN_CLR: prot_nxt = prot_q & ~req;
      default: prot_nxt = prot_q;
    endcase
  end

  // State changes on the access edge.
  always_ff @(posedge clk) begin
    if (rst)            prot_q <= '0;
    else if (wr_commit) prot_q <= prot_nxt;
  end

  // Response registered on the setup edge, valid through the access cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      prdata  <= '0;
      pslverr <= 1'b0;
    end else begin
      pslverr <= setup_ph & pwrite & dup;
      if (setup_ph && !pwrite && win != WIN_NONE) prdata <= DATA_W'(prot_q);
      else                                        prdata <= '0;
    end
  end

  assign prot_o = prot_q;

endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
  parameter int NUM_PERIPH = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PERIPH-1:0] bus_sel_i,
  input  logic                  bus_enable_i,
  input  logic                  bus_write_i,
  input  logic                  dbg_access_i,
  input  logic [NUM_PERIPH-1:0] prot_i,
  input  logic                  dev_ready_i,
  input  logic                  dev_slverr_i,
  output logic                  dev_enable_o,
  output logic                  bus_ready_o,
  output logic                  bus_slverr_o
);

  logic hit_prot;
  logic blk_q;

  assign hit_prot = |(bus_sel_i & prot_i);

  // Decision taken on the setup edge; it falls on the access edge because
  // the enable is high there.
  always_ff @(posedge clk) begin
    if (rst) blk_q <= 1'b0;
    else     blk_q <= ~bus_enable_i & bus_write_i & ~dbg_access_i & hit_prot;
  end

  assign dev_enable_o = bus_enable_i & ~blk_q;
  assign bus_ready_o  = blk_q | dev_ready_i;
  assign bus_slverr_o = blk_q | dev_slverr_i;

endmodule

// File: rtl/apb_wprot_ctrl.sv
module apb_wprot_ctrl #(
  parameter int NUM_PERIPH = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [DATA_W-1:0]     pwdata,
  output logic [DATA_W-1:0]     prdata,
  output logic                  pready,
  output logic                  pslverr,
  input  logic [NUM_PERIPH-1:0] bus_sel_i,
  input  logic                  bus_enable_i,
  input  logic                  bus_write_i,
  input  logic                  dbg_access_i,
  input  logic                  dev_ready_i,
  input  logic                  dev_slverr_i,
  output logic                  dev_enable_o,
  output logic                  bus_ready_o,
  output logic                  bus_slverr_o
);

  logic [NUM_PERIPH-1:0] prot_vec;

  wprot_regs #(
    .NUM_PERIPH(NUM_PERIPH),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .psel   (psel),
    .penable(penable),
    .pwrite (pwrite),
    .paddr  (paddr),
    .pwdata (pwdata),
    .prdata (prdata),
    .pslverr(pslverr),
    .prot_o (prot_vec)
  );

  wprot_gate #(
    .NUM_PERIPH(NUM_PERIPH)
  ) u_gate (
    .clk         (clk),
    .rst         (rst),
    .bus_sel_i   (bus_sel_i),
    .bus_enable_i(bus_enable_i),
    .bus_write_i (bus_write_i),
    .dbg_access_i(dbg_access_i),
    .prot_i      (prot_vec),
    .dev_ready_i (dev_ready_i),
    .dev_slverr_i(dev_slverr_i),
    .dev_enable_o(dev_enable_o),
    .bus_ready_o (bus_ready_o),
    .bus_slverr_o(bus_slverr_o)
  );

  assign pready = 1'b1;

endmodule

// File: rtl/wprot_checker.sv
module wprot_checker #(
  parameter int NUM_PERIPH = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  psel,
  input logic                  penable,
  input logic                  pwrite,
  input logic [ADDR_W-1:0]     paddr,
  input logic [DATA_W-1:0]     pwdata,
  input logic [DATA_W-1:0]     prdata,
  input logic                  pready,
  input logic                  pslverr,
  input logic [NUM_PERIPH-1:0] bus_sel_i,
  input logic                  bus_enable_i,
  input logic                  bus_write_i,
  input logic                  dbg_access_i,
  input logic                  dev_ready_i,
  input logic                  dev_slverr_i,
  input logic                  dev_enable_o,
  input logic                  bus_ready_o,
  input logic                  bus_slverr_o,
  input logic [NUM_PERIPH-1:0] prot_vec
);

  logic                  acc;
  logic                  is_clr;
  logic                  is_set;
  logic [NUM_PERIPH-1:0] wd;
  logic                  unused_w;

  assign acc      = psel & penable;
  assign is_clr   = (paddr == ADDR_W'(0));
  assign is_set   = (paddr == ADDR_W'(4));
  assign wd       = pwdata[NUM_PERIPH-1:0];
  assign unused_w = ^pwdata[DATA_W-1:NUM_PERIPH];

  p_set_update_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && pwrite && is_set) |=> (prot_vec == ($past(prot_vec) | $past(wd))));

  p_clr_update_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && pwrite && is_clr) |=> (prot_vec == ($past(prot_vec) & ~$past(wd))));

  p_read_back_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && !pwrite && (is_set || is_clr)) |-> (prdata == DATA_W'(prot_vec)));

  p_set_dup_err_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && pwrite && is_set) |-> (pslverr == |(wd & prot_vec)));

  p_clr_dup_err_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && pwrite && is_clr) |-> (pslverr == |(wd & ~prot_vec)));

  // R7 and R11: decision uses the state seen in the setup cycle.
  p_block_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_enable_i && bus_write_i && !$past(bus_enable_i) && $past(bus_write_i)
     && (|(bus_sel_i & $past(prot_vec))) && !$past(dbg_access_i))
    |-> (!dev_enable_o && bus_ready_o && bus_slverr_o));

  p_debug_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_enable_i && bus_write_i && !$past(bus_enable_i) && $past(dbg_access_i))
    |-> (dev_enable_o && (bus_slverr_o == dev_slverr_i)));

  p_read_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_enable_i && !bus_write_i)
    |-> (dev_enable_o && (bus_ready_o == dev_ready_i) && (bus_slverr_o == dev_slverr_i)));

  p_no_wait_r10: assert property (@(posedge clk) disable iff (rst) pready);

  p_err_access_only_r10: assert property (@(posedge clk) disable iff (rst)
    !acc |-> !pslverr);

endmodule

bind apb_wprot_ctrl wprot_checker #(
  .NUM_PERIPH(NUM_PERIPH),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .psel        (psel),
  .penable     (penable),
  .pwrite      (pwrite),
  .paddr       (paddr),
  .pwdata      (pwdata),
  .prdata      (prdata),
  .pready      (pready),
  .pslverr     (pslverr),
  .bus_sel_i   (bus_sel_i),
  .bus_enable_i(bus_enable_i),
  .bus_write_i (bus_write_i),
  .dbg_access_i(dbg_access_i),
  .dev_ready_i (dev_ready_i),
  .dev_slverr_i(dev_slverr_i),
  .dev_enable_o(dev_enable_o),
  .bus_ready_o (bus_ready_o),
  .bus_slverr_o(bus_slverr_o),
  .prot_vec    (prot_vec)
);

// File: tb/sim_apb_wprot_ctrl.sv
`timescale 1ns/1ps
module sim_apb_wprot_ctrl;

  localparam int NP = 4;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_CLR = 8'h00;
  localparam logic [AW-1:0] A_SET = 8'h04;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic          pready, pslverr;
  logic [NP-1:0] bus_sel_i = '0;
  logic          bus_enable_i = 1'b0, bus_write_i = 1'b0, dbg_access_i = 1'b0;
  logic          dev_ready_i = 1'b1, dev_slverr_i = 1'b0;
  logic          dev_enable_o, bus_ready_o, bus_slverr_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  apb_wprot_ctrl #(.NUM_PERIPH(NP), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .bus_sel_i(bus_sel_i), .bus_enable_i(bus_enable_i),
    .bus_write_i(bus_write_i), .dbg_access_i(dbg_access_i),
    .dev_ready_i(dev_ready_i), .dev_slverr_i(dev_slverr_i),
    .dev_enable_o(dev_enable_o), .bus_ready_o(bus_ready_o),
    .bus_slverr_o(bus_slverr_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One register transfer; response sampled inside the access cycle.
  task automatic reg_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output logic er);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd = prdata; er = pslverr;
    chk("R10 pready", {31'd0, pready}, 32'd1);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    #1;
    if (er) chk("R10 err outside access", {31'd0, pslverr}, 32'd0);
  endtask

  task automatic dev_op(input int idx, input bit wr, input bit dbg, input bit drdy,
                        input bit derr, output logic en, output logic rdy, output logic er);
    @(negedge clk);
    bus_sel_i = NP'(1) << idx; bus_write_i = wr; dbg_access_i = dbg; bus_enable_i = 1'b0;
    dev_ready_i = drdy; dev_slverr_i = derr;
    @(negedge clk);
    bus_enable_i = 1'b1;
    #1;
    en = dev_enable_o; rdy = bus_ready_o; er = bus_slverr_o;
    @(negedge clk);
    bus_sel_i = '0; bus_enable_i = 1'b0; bus_write_i = 1'b0; dbg_access_i = 1'b0;
  endtask

  task automatic load_state(input logic [NP-1:0] s);
    logic [DW-1:0] rd;
    logic er;
    reg_op(1'b1, A_CLR, DW'(4'hF), rd, er);
    reg_op(1'b1, A_SET, DW'(s), rd, er);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DW-1:0] rd;
    logic er, en, rdy, blk, derr, drdy;
    logic [NP-1:0] exp_s;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    #1;
    chk("R1 pslverr", {31'd0, pslverr}, 32'd0);
    reg_op(1'b0, A_SET, '0, rd, er);
    chk("R1 set alias", rd, 32'd0);
    reg_op(1'b0, A_CLR, '0, rd, er);
    chk("R1 clr alias", rd, 32'd0);

    // R2/R3/R5/R6: every start state, every write pattern, both aliases.
    for (int op = 0; op < 2; op++) begin
      for (int s = 0; s < 16; s++) begin
        for (int w = 0; w < 16; w++) begin
          load_state(NP'(s));
          reg_op(1'b0, A_SET, '0, rd, er);
          chk("R4 load read", rd, DW'(s));
          if (op == 0) begin
            reg_op(1'b1, A_SET, {28'hFFFFFFF, 4'(w)}, rd, er);
            chk("R5 dup set err", {31'd0, er}, {31'd0, |(4'(w) & 4'(s))});
            exp_s = 4'(s) | 4'(w);
            reg_op(1'b0, A_CLR, '0, rd, er);
            chk("R2 set result", rd, DW'(exp_s));
          end else begin
            reg_op(1'b1, A_CLR, DW'(w), rd, er);
            chk("R6 dup clr err", {31'd0, er}, {31'd0, |(4'(w) & ~4'(s))});
            exp_s = 4'(s) & ~4'(w);
            reg_op(1'b0, A_SET, '0, rd, er);
            chk("R3 clr result", rd, DW'(exp_s));
          end
        end
      end
    end

    // R4: other and unaligned addresses
    load_state(4'h5);
    for (int a = 1; a < 16; a++) begin
      if (a != 4) begin
        reg_op(1'b1, AW'(a), DW'(4'hA), rd, er);
        chk("R4 other addr no err", {31'd0, er}, 32'd0);
        reg_op(1'b0, AW'(a), '0, rd, er);
        chk("R4 other addr reads 0", rd, 32'd0);
      end
    end
    reg_op(1'b0, A_CLR, '0, rd, er);
    chk("R4 state untouched", rd, 32'h5);

    // R7/R8/R9: downstream gating sweep.
    for (int s = 0; s < 16; s++) begin
      load_state(NP'(s));
      for (int idx = 0; idx < NP; idx++) begin
        for (int wr = 0; wr < 2; wr++) begin
          for (int dbg = 0; dbg < 2; dbg++) begin
            derr = 1'(idx);
            drdy = 1'(idx >> 1);
            blk  = (wr == 1) && s[idx] && (dbg == 0);
            dev_op(idx, wr[0], dbg[0], drdy, derr, en, rdy, er);
            if (wr == 0)      chk("R9 read passes", {31'd0, en}, 32'd1);
            else if (dbg == 1) chk("R8 debug passes", {31'd0, en}, 32'd1);
            else              chk("R7 gate enable", {31'd0, en}, {31'd0, !blk});
            chk("R7 R9 ready", {31'd0, rdy}, {31'd0, blk | drdy});
            chk("R7 R9 slverr", {31'd0, er}, {31'd0, blk | derr});
          end
        end
      end
    end

    // R11: register access edge coincides with downstream setup edge.
    load_state(4'h0);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = A_SET; pwdata = 32'h4;
    @(negedge clk);
    penable = 1'b1;
    bus_sel_i = 4'h4; bus_write_i = 1'b1; bus_enable_i = 1'b0; dev_slverr_i = 1'b0; dev_ready_i = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; bus_enable_i = 1'b1;
    #1;
    chk("R11 old state unprotected", {31'd0, dev_enable_o}, 32'd1);
    chk("R11 old state no err", {31'd0, bus_slverr_o}, 32'd0);
    @(negedge clk);
    bus_sel_i = '0; bus_enable_i = 1'b0; bus_write_i = 1'b0;
    dev_op(2, 1'b1, 1'b0, 1'b1, 1'b0, en, rdy, er);
    chk("R11 new state blocks", {31'd0, en}, 32'd0);

    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = A_CLR; pwdata = 32'h4;
    @(negedge clk);
    penable = 1'b1;
    bus_sel_i = 4'h4; bus_write_i = 1'b1; bus_enable_i = 1'b0;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; bus_enable_i = 1'b1;
    #1;
    chk("R11 old state protected", {31'd0, dev_enable_o}, 32'd0);
    chk("R11 old state err", {31'd0, bus_slverr_o}, 32'd1);
    @(negedge clk);
    bus_sel_i = '0; bus_enable_i = 1'b0; bus_write_i = 1'b0;
    dev_op(2, 1'b1, 1'b0, 1'b1, 1'b0, en, rdy, er);
    chk("R11 new state passes", {31'd0, en}, 32'd1);

    summary();
  end

endmodule